// File: doc/BRIEF.md
# User Data Double Buffer

This block sits behind the subframe decoder of a serial digital audio receiver. It collects the user (U) bit that each subframe carries. Bits from the first subframe of a frame (channel A) and from the second (channel B) are written, in the order they arrive, into a capture store that holds one block per channel. When the preamble that starts a new block arrives, the whole capture store is copied into a second, host-visible store in a single clock edge. A host read therefore returns either the data from before the copy or the data from after it, and never a mix of the two.

The host reads the visible store one 16-bit word at a time. Each word holds one byte of channel A and the matching byte of channel B, with their bits interleaved. A read returns data only while the host has selected the user-data space. When a copy alters any stored bit, a sticky flag is set. The flag drives the interrupt line through a mask bit, and a host acknowledge clears it.

Top module: `ub_user_dbuf`

## Requirements
- R1: A U bit with `ubit_sub`=0 is stored in channel A and one with `ubit_sub`=1 in channel B. Each is stored at the next bit position of its channel, counted from 0 at the block start. Bits past position FRAMES-1 (191) in a block are dropped.
- R2: When `blk_start` is high, the visible store takes the whole capture content in that same clock edge. A U bit presented in that cycle is the first bit (position 0) of the new block and is not part of the copy. The visible store does not change in any other cycle.
- R3: A copy that changes at least one bit of the visible store sets the sticky change flag.
- R4: A copy that leaves every bit of the visible store unchanged does not set the flag.
- R5: A high `irq_ack` clears the flag. If a setting copy happens in the same cycle, the set wins.
- R6: `host_rdata` for word index w (0..23) has bit 15-2i equal to channel A bit 8w+i and bit 14-2i equal to channel B bit 8w+i, for i = 0..7. The earliest received bit therefore lands in the byte MSB, and word 0 holds the first received bytes.
- R7: While `host_sel_user` is 0, `host_rdata` is 0.
- R8: `irq` equals the flag ANDed with `irq_mask`.
- R9: After reset, both stores and the flag are zero.
- R10: A word index of 24 or above reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ubit_valid | input | 1 | A U bit is present this cycle |
| ubit_sub | input | 1 | Subframe of the bit: 0 = A, 1 = B |
| ubit_val | input | 1 | Value of the U bit |
| blk_start | input | 1 | Block-start preamble seen; triggers the copy |
| host_sel_user | input | 1 | Host has selected the user-data space |
| host_addr | input | 5 | Word index for the read |
| host_rdata | output | 16 | Interleaved read word |
| irq_mask | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the change flag |
| irq | output | 1 | Change interrupt |

## Verification
A full block of pseudo-random bits sets the flag, and resending that same block must leave the flag clear. This pair separates a real comparison against the stored content from a flag that simply fires on every copy. A block with a single flipped bit, read out at every word index, shows whether the compare looks at every bit position and whether the A/B interleave and the bit order within each byte are correct. A partial block, an over-long block, a block start that coincides with a data bit, and periods with the select or mask low cover the pointer restart, the dropping of excess bits, the copy-before-write ordering and the output gating.

// File: rtl/ub_pkg.sv
package ub_pkg;
    typedef enum logic {SUB_A = 1'b0, SUB_B = 1'b1} ub_sub_e;

    typedef struct packed {
        logic [7:0] a_byte;
        logic [7:0] b_byte;
    } ub_pair_t;

    // interleave two bytes: bit 15 = a[7], bit 14 = b[7], ... bit 0 = b[0]
    function automatic logic [15:0] ub_weave(input ub_pair_t p);
        logic [15:0] w;
        for (int i = 0; i < 8; i++) begin
            w[2*i+1] = p.a_byte[i];
            w[2*i]   = p.b_byte[i];
        end
        return w;
    endfunction
endpackage

// File: rtl/ub_capture.sv
module ub_capture #(
    parameter int FRAMES = 192
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_valid,
    input  logic                   bit_sub,
    input  logic                   bit_val,
    input  logic                   blk_start,
    output logic [1:0][FRAMES-1:0] d_store
);
    localparam int PW = $clog2(FRAMES + 1);

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic [PW-1:0]     ptr;
        logic [PW-1:0]     wr_idx;
        logic              hit;
        logic [FRAMES-1:0] mem;

        assign hit    = bit_valid && (bit_sub == ch[0]);
        assign wr_idx = blk_start ? '0 : ptr;

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr <= '0;
                mem <= '0;
            end else begin
                if (hit && (wr_idx < PW'(FRAMES)))
                    mem[wr_idx] <= bit_val;
                if (blk_start)
                    ptr <= hit ? PW'(1) : '0;
                else if (hit && (ptr < PW'(FRAMES)))
                    ptr <= ptr + PW'(1);
            end
        end

        assign d_store[ch] = mem;

        p_ptr_bound_r1: assert property (@(posedge clk) disable iff (rst)
            ptr <= PW'(FRAMES));
        p_ptr_restart_r1: assert property (@(posedge clk) disable iff (rst)
            blk_start && !hit |=> ptr == '0);
    end
endmodule

// File: rtl/ub_store.sv
module ub_store #(
    parameter int FRAMES = 192
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xfer,
    input  logic [1:0][FRAMES-1:0] d_store,
    output logic [1:0][FRAMES-1:0] e_store,
    output logic                   changed
);
    assign changed = xfer && (d_store != e_store);

    always_ff @(posedge clk) begin
        if (rst)
            e_store <= '0;
        else if (xfer)
            e_store <= d_store;
    end

    p_e_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(e_store));
endmodule

// File: rtl/ub_irq.sv
module ub_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    input  logic mask,
    output logic irq
);
    logic flag;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (ack)
            flag <= 1'b0;
    end

    assign irq = flag & mask;

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    p_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set));
    p_ack_r5: assert property (@(posedge clk) disable iff (rst)
        ack && !set |=> !flag);
    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !mask |-> !irq);
endmodule

// File: rtl/ub_user_dbuf.sv
module ub_user_dbuf
    import ub_pkg::*;
#(
    parameter int FRAMES = 192,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ubit_valid,
    input  logic              ubit_sub,
    input  logic              ubit_val,
    input  logic              blk_start,
    input  logic              host_sel_user,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [15:0]       host_rdata,
    input  logic              irq_mask,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int WORDS = FRAMES / 8;

    logic [1:0][FRAMES-1:0] d_store;
    logic [1:0][FRAMES-1:0] e_store;
    logic                   changed;
    ub_pair_t               pair;

    ub_capture #(.FRAMES(FRAMES)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (ubit_valid),
        .bit_sub   (ubit_sub),
        .bit_val   (ubit_val),
        .blk_start (blk_start),
        .d_store   (d_store)
    );

    ub_store #(.FRAMES(FRAMES)) sto_i (
        .clk     (clk),
        .rst     (rst),
        .xfer    (blk_start),
        .d_store (d_store),
        .e_store (e_store),
        .changed (changed)
    );

    ub_irq irq_i (
        .clk  (clk),
        .rst  (rst),
        .set  (changed),
        .ack  (irq_ack),
        .mask (irq_mask),
        .irq  (irq)
    );

    // earliest bit of a byte goes to its MSB
    always_comb begin
        pair = '0;
        if (int'(host_addr) < WORDS) begin
            for (int i = 0; i < 8; i++) begin
                pair.a_byte[7-i] = e_store[SUB_A][8*int'(host_addr)+i];
                pair.b_byte[7-i] = e_store[SUB_B][8*int'(host_addr)+i];
            end
        end
    end

    assign host_rdata = host_sel_user ? ub_weave(pair) : 16'h0000;

    p_sel_r7: assert property (@(posedge clk) disable iff (rst)
        !host_sel_user |-> host_rdata == 16'h0000);
    p_range_r10: assert property (@(posedge clk) disable iff (rst)
        int'(host_addr) >= WORDS |-> host_rdata == 16'h0000);
endmodule

// File: tb/ub_user_dbuf_tb_top.sv
module ub_user_dbuf_tb_top;
    localparam int FRAMES = 192;
    localparam int WORDS  = FRAMES / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ubit_valid = 0, ubit_sub = 0, ubit_val = 0, blk_start = 0;
    logic host_sel_user = 1'b1;
    logic [4:0] host_addr = '0;
    logic [15:0] host_rdata;
    logic irq_mask = 1'b1, irq_ack = 1'b0;
    logic irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit m_d [2][FRAMES];
    bit m_e [2][FRAMES];
    int m_p [2];
    bit m_flag;
    bit pat [2][FRAMES];

    always #5 clk = ~clk;

    ub_user_dbuf dut_i (
        .clk(clk), .rst(rst), .ubit_valid(ubit_valid), .ubit_sub(ubit_sub),
        .ubit_val(ubit_val), .blk_start(blk_start), .host_sel_user(host_sel_user),
        .host_addr(host_addr), .host_rdata(host_rdata), .irq_mask(irq_mask),
        .irq_ack(irq_ack), .irq(irq)
    );

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_p[c] = 0;
                for (int k = 0; k < FRAMES; k++) begin m_d[c][k] = 0; m_e[c][k] = 0; end
            end
            m_flag = 0;
        end else begin
            bit chg;
            chg = 0;
            if (blk_start) begin   // R2: copy before the new bit lands
                for (int c = 0; c < 2; c++)
                    for (int k = 0; k < FRAMES; k++) begin
                        if (m_e[c][k] != m_d[c][k]) chg = 1;
                        m_e[c][k] = m_d[c][k];
                    end
                m_p[0] = 0; m_p[1] = 0;
            end
            if (irq_ack) m_flag = 0;       // R5
            if (chg) m_flag = 1;           // R3 R4
            if (ubit_valid) begin          // R1
                int s;
                s = ubit_sub ? 1 : 0;
                if (m_p[s] < FRAMES) begin
                    m_d[s][m_p[s]] = ubit_val;
                    m_p[s]++;
                end
            end
        end
    end

    function automatic logic [15:0] exp_word(int a);
        logic [15:0] w;
        w = '0;
        if (host_sel_user && a < WORDS)
            for (int i = 0; i < 8; i++) begin
                w[15-2*i] = m_e[0][8*a+i];
                w[14-2*i] = m_e[1][8*a+i];
            end
        return w;
    endfunction

    // compare every clock, shortly after the edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [15:0] ew;
            logic ei;
            ew = exp_word(int'(host_addr));
            ei = m_flag & irq_mask;
            n_cmp++;
            if (host_rdata !== ew) begin
                n_bad++;
                $display("FAIL R1 R2 R6 R7 R9 R10 rdata addr=%0d sel=%0b actual=%h expected=%h",
                         host_addr, host_sel_user, host_rdata, ew);
            end
            n_cmp++;
            if (irq !== ei) begin
                n_bad++;
                $display("FAIL R3 R4 R5 R8 R9 irq actual=%0b expected=%0b", irq, ei);
            end
        end
    end

    // address sweep keeps every word under observation
    always @(negedge clk) host_addr <= (host_addr == 5'd25) ? 5'd0 : host_addr + 5'd1;

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ubit_valid = 0; blk_start = 0; irq_ack = 0;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        ubit_valid = 0; blk_start = 0; irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    // send nfr frames of pat; merge=1 puts blk_start on the first A bit
    task automatic send_block(int nfr, bit merge);
        if (!merge) begin
            @(negedge clk);
            ubit_valid = 0; irq_ack = 0; blk_start = 1;
        end
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                blk_start = (merge && f == 0 && s == 0);
                irq_ack = 0;
                ubit_valid = 1; ubit_sub = s[0];
                ubit_val = pat[s][f % FRAMES] ^ (f >= FRAMES);
            end
        end
        @(negedge clk);
        ubit_valid = 0; blk_start = 0;
    endtask

    task automatic kick();   // lone block start to copy D into E
        @(negedge clk);
        ubit_valid = 0; irq_ack = 0; blk_start = 1;
        @(negedge clk);
        blk_start = 0;
    endtask

    initial begin
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < FRAMES; k++) pat[c][k] = $urandom_range(0, 1);
        repeat (3) @(negedge clk);
        rst = 0;
        idle(30);                       // R9 reset state checked by sweep
        send_block(FRAMES, 0);          // R1 full random block
        kick(); idle(30);               // R2 R3 R6 copy, flag set
        ack(); idle(5);                 // R5
        send_block(FRAMES, 0); kick(); idle(30);   // R4 same data, no flag
        pat[1][77] = ~pat[1][77];       // single-bit change in channel B
        irq_mask = 0;
        send_block(FRAMES, 0); kick(); idle(10);   // R8 masked
        irq_mask = 1; idle(30);         // R3 flag visible once unmasked
        host_sel_user = 0; idle(30);    // R7
        host_sel_user = 1;
        ack(); idle(3);
        send_block(FRAMES + 8, 1);      // R1 excess dropped, R2 merged start
        kick(); idle(30);
        send_block(50, 1);              // partial block
        @(negedge clk);                 // R5 ack and set in one cycle
        blk_start = 1; irq_ack = 1;
        @(negedge clk);
        blk_start = 0; irq_ack = 0;
        idle(30);
        ack(); idle(30);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule